// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Path-Metric Unit

This block updates the path metrics of four trellis states in a state-parallel Viterbi detector. The four destination states share the same four predecessor states, and each destination has one inbound branch from each predecessor. So the unit holds one captured copy of the four predecessor metrics. Two identical add-compare-select datapaths read that copy. Each datapath serves one destination state on a first pass and a second destination state on the cycle after. A trellis of many states is built from several of these units, with metric routing between them handled outside.

A one-cycle start strobe opens a symbol iteration. In that cycle the unit captures the four predecessor metrics and all sixteen branch metrics. Every candidate is a predecessor metric plus a branch metric, and the sum wraps modulo 2^SM_W, so no renormalisation is ever done. The best of four candidates is found in two pipelined rounds. The first round compares two pairs, and the second round compares the two pair winners. Each comparison takes the sign of the wrapped difference. The four new metrics are registered together in one fixed cycle, so the output can be fed back in time for a start strobe seven cycles after the previous one. Decision bits leave the unit one pass at a time with a valid strobe, for use by a survivor memory.

Top module: `acs4_radix4_unit`

## Requirements
- R1: While rst_n is low, and after it is released with no start strobe, sm_o is all zero and dec_vld_o is low.
- R2: For destination state s, candidate b is (predecessor metric b + branch metric (s,b)) mod 2^SM_W. Branch metric (s,b) sits at bm_i bits [(4s+b)*BM_W +: BM_W] and predecessor metric b at pred_sm_i bits [b*SM_W +: SM_W]. The new metric of state s is the smallest candidate, where x is smaller than y when (x - y) mod 2^SM_W, read as a signed SM_W-bit number, is negative.
- R3: When two compared candidates are equal, the one with the lower branch index wins.
- R4: The 2-bit decision of a state is the index of its winning branch. Bit 1 says whether the winner came from branches {2,3} (1) or {0,1} (0). Bit 0 gives the member within that pair.
- R5: If sym_start_i is high in cycle n, then in cycle n+6 dec_vld_o is high and dec_pass_o is 0, with dec_o[1:0] for state 0 and dec_o[3:2] for state 1. In cycle n+7 dec_vld_o is high and dec_pass_o is 1, with dec_o[1:0] for state 2 and dec_o[3:2] for state 3.
- R6: All four metrics on sm_o (state s at bits [s*SM_W +: SM_W]) change together and show the new values from cycle n+7 on. They hold their value at all other times.
- R7: pred_sm_i and bm_i are sampled only in a cycle with sym_start_i high. Changes to them in any other cycle have no effect on any output.
- R8: Start strobes may come exactly seven cycles apart, with sm_o fed straight back as predecessor metrics. Each iteration then gives the results of R2 to R6.
- R9: Results follow R2 even when candidate sums wrap past 2^SM_W, provided the spread of the four candidates of a state is below 2^(SM_W-1).
- R10: dec_vld_o is low in every cycle other than the two cycles per iteration named in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_start_i | input | 1 | Start of a symbol iteration; captures the metric inputs |
| pred_sm_i | input | 4*SM_W | Predecessor state metrics, branch b at [b*SM_W +: SM_W] |
| bm_i | input | 16*BM_W | Branch metrics, state s branch b at [(4s+b)*BM_W +: BM_W] |
| sm_o | output | 4*SM_W | Updated state metrics, state s at [s*SM_W +: SM_W] |
| dec_vld_o | output | 1 | Decision bits valid this cycle |
| dec_pass_o | output | 1 | 0: decisions for states 0,1; 1: decisions for states 2,3 |
| dec_o | output | 4 | Two 2-bit winning-branch indices for the current pass |

## Verification
The assertions take two things for granted. First, start strobes are never closer than seven cycles, and an assertion on that spacing guards this input. Second, the four candidates of any state stay within half the modulus of each other, without which the sign comparison has no meaning. The stimulus keeps predecessor metrics within 400 of a random base, which can sit next to the wrap point. Branch metrics stay below 512, so a spread never reaches 1024. In the closed-loop phase the fed-back metrics stay within one branch metric of each other. Tie-heavy phases draw from tiny value ranges so that equal candidates occur often. Between strobes the metric inputs are driven with unrestricted random values.

// File: rtl/acs4_pkg.sv
package acs4_pkg;
  // Inbound branches per state and states per unit.
  localparam int RADIX = 4;
  // Passes each datapath makes per symbol iteration.
  localparam int NPASS = 2;
  // Datapaths per unit.
  localparam int NDP = RADIX / NPASS;
  // Width of the winning-branch index.
  localparam int DEC_W = $clog2(RADIX);
  // Register stages after the shared capture stage.
  localparam int PIPE_DEPTH = 5;
  // Stage-enable positions.
  localparam int ST_ADD  = 0;
  localparam int ST_CMP1 = 1;
  localparam int ST_SEL1 = 2;
  localparam int ST_CMP2 = 3;
  localparam int ST_SEL2 = 4;
endpackage

// File: rtl/acs4_round.sv
module acs4_round #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] win_o,
  output logic         take_b_o
);
  logic [W-1:0] a_q, b_q, diff_q, diff_d;

  always_comb begin
    diff_d   = a_i - b_i;
    take_b_o = ~diff_q[W-1] & (|diff_q);
    win_o    = take_b_o ? b_q : a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      diff_q <= '0;
    end else if (cmp_en_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      diff_q <= diff_d;
    end
  end

  AST_TIE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en_i && (a_i == b_i)) |=> !take_b_o); // R3
endmodule

// File: rtl/acs4_datapath.sv
module acs4_datapath
  import acs4_pkg::*;
#(
  parameter int SM_W = 11,
  parameter int BM_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PIPE_DEPTH-1:0]   en_i,
  input  logic [RADIX*SM_W-1:0]   sm_i,
  input  logic [RADIX*BM_W-1:0]   bm_i,
  output logic [SM_W-1:0]         metric_nxt_o,
  output logic [SM_W-1:0]         metric_o,
  output logic [DEC_W-1:0]        dec_o
);
  localparam int NPAIR = RADIX / 2;

  logic [SM_W-1:0] cand_d [RADIX];
  logic [SM_W-1:0] cand_q [RADIX];
  logic [SM_W-1:0] w1_d   [NPAIR];
  logic [SM_W-1:0] w1_q   [NPAIR];
  logic [NPAIR-1:0] s1_d, s1_q, carry_q;
  logic            s2_d, s2_q, lo_d, lo_q;

  // Path-metric add: wraps modulo 2^SM_W.
  always_comb begin
    for (int b = 0; b < RADIX; b++) begin
      cand_d[b] = sm_i[b*SM_W +: SM_W]
                + {{(SM_W-BM_W){1'b0}}, bm_i[b*BM_W +: BM_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < RADIX; b++) cand_q[b] <= '0;
    end else if (en_i[ST_ADD]) begin
      for (int b = 0; b < RADIX; b++) cand_q[b] <= cand_d[b];
    end
  end

  // First round: pairwise compare, then select.
  for (genvar p = 0; p < NPAIR; p++) begin : g_r1
    acs4_round #(.W(SM_W)) u_round (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_en_i (en_i[ST_CMP1]),
      .a_i      (cand_q[2*p]),
      .b_i      (cand_q[2*p+1]),
      .win_o    (w1_d[p]),
      .take_b_o (s1_d[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAIR; p++) w1_q[p] <= '0;
      s1_q <= '0;
    end else if (en_i[ST_SEL1]) begin
      for (int p = 0; p < NPAIR; p++) w1_q[p] <= w1_d[p];
      s1_q <= s1_d;
    end
  end

  // First-round decisions travel beside the second compare.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                carry_q <= '0;
    else if (en_i[ST_CMP2])    carry_q <= s1_q;
  end

  // Second round between the two pair winners.
  acs4_round #(.W(SM_W)) u_round2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_en_i (en_i[ST_CMP2]),
    .a_i      (w1_q[0]),
    .b_i      (w1_q[1]),
    .win_o    (metric_nxt_o),
    .take_b_o (s2_d)
  );

  always_comb lo_d = s2_d ? carry_q[1] : carry_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metric_o <= '0;
      s2_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else if (en_i[ST_SEL2]) begin
      metric_o <= metric_nxt_o;
      s2_q     <= s2_d;
      lo_q     <= lo_d;
    end
  end

  always_comb dec_o = {s2_q, lo_q};
endmodule

// File: rtl/acs4_ctrl.sv
module acs4_ctrl
  import acs4_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  output logic [PIPE_DEPTH-1:0] en_o,
  output logic                  pass_add_o,
  output logic                  dec_vld_o,
  output logic                  dec_pass_o,
  output logic                  sm_wr_o
);
  logic [NPASS-1:0]      iss_q, iss_d;
  logic [PIPE_DEPTH-1:0] vld_q, vld_d, pas_q, pas_d;
  logic                  en_add;

  always_comb begin
    iss_d      = {iss_q[NPASS-2:0], start_i};
    en_add     = |iss_q;
    pass_add_o = iss_q[NPASS-1];
    vld_d      = {vld_q[PIPE_DEPTH-2:0], en_add};
    pas_d      = {pas_q[PIPE_DEPTH-2:0], pass_add_o};
    en_o       = {vld_q[PIPE_DEPTH-2:0], en_add};
    dec_vld_o  = vld_q[PIPE_DEPTH-1];
    dec_pass_o = pas_q[PIPE_DEPTH-1];
    sm_wr_o    = vld_q[PIPE_DEPTH-2] & pas_q[PIPE_DEPTH-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
      vld_q <= '0;
      pas_q <= '0;
    end else begin
      iss_q <= iss_d;
      vld_q <= vld_d;
      pas_q <= pas_d;
    end
  end

  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld_o && dec_pass_o) |-> $past(dec_vld_o && !dec_pass_o)); // R5
endmodule

// File: rtl/acs4_radix4_unit.sv
module acs4_radix4_unit
  import acs4_pkg::*;
#(
  parameter int SM_W     = 11,
  parameter int BM_W     = 9,
  parameter int ITER_LEN = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sym_start_i,
  input  logic [RADIX*SM_W-1:0]        pred_sm_i,
  input  logic [RADIX*RADIX*BM_W-1:0]  bm_i,
  output logic [RADIX*SM_W-1:0]        sm_o,
  output logic                         dec_vld_o,
  output logic                         dec_pass_o,
  output logic [NDP*DEC_W-1:0]         dec_o
);
  localparam int ROW_W = RADIX * BM_W;
  localparam int CNT_W = $clog2(ITER_LEN + 1);

  logic [RADIX*SM_W-1:0]       pred_q;
  logic [RADIX*RADIX*BM_W-1:0] bm_q;
  logic [RADIX*SM_W-1:0]       sm_q, sm_d;
  logic [PIPE_DEPTH-1:0]       stage_en;
  logic                        pass_add, sm_wr;
  logic [SM_W-1:0]             m_nxt [NDP];
  logic [SM_W-1:0]             m_cur [NDP];

  // Shared capture stage, loaded once per iteration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      bm_q   <= '0;
    end else if (sym_start_i) begin
      pred_q <= pred_sm_i;
      bm_q   <= bm_i;
    end
  end

  acs4_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (sym_start_i),
    .en_o       (stage_en),
    .pass_add_o (pass_add),
    .dec_vld_o  (dec_vld_o),
    .dec_pass_o (dec_pass_o),
    .sm_wr_o    (sm_wr)
  );

  for (genvar d = 0; d < NDP; d++) begin : g_dp
    logic [ROW_W-1:0] bm_row;
    always_comb bm_row = pass_add ? bm_q[(d+NDP)*ROW_W +: ROW_W]
                                  : bm_q[d*ROW_W +: ROW_W];
    acs4_datapath #(.SM_W(SM_W), .BM_W(BM_W)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (stage_en),
      .sm_i         (pred_q),
      .bm_i         (bm_row),
      .metric_nxt_o (m_nxt[d]),
      .metric_o     (m_cur[d]),
      .dec_o        (dec_o[d*DEC_W +: DEC_W])
    );
  end

  // Output routing register: first-pass results sit in the final stage
  // while second-pass results leave the last select.
  always_comb begin
    sm_d = sm_q;
    if (sm_wr) begin
      for (int d = 0; d < NDP; d++) begin
        sm_d[d*SM_W +: SM_W]       = m_cur[d];
        sm_d[(d+NDP)*SM_W +: SM_W] = m_nxt[d];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sm_q <= '0;
    else        sm_q <= sm_d;
  end

  assign sm_o = sm_q;

  // Cycles since the last start strobe, saturating; used by checks only.
  logic [CNT_W-1:0] since_q, since_d;
  always_comb begin
    if (sym_start_i)                         since_d = '0;
    else if (since_q == CNT_W'(ITER_LEN))    since_d = since_q;
    else                                     since_d = since_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= CNT_W'(ITER_LEN);
    else        since_q <= since_d;
  end

  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start_i |-> (since_q >= CNT_W'(ITER_LEN - 1))); // R8
  AST_DEC_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld_o && !dec_pass_o) |-> (since_q == CNT_W'(PIPE_DEPTH))); // R5
  AST_SM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sm_o) |-> (dec_vld_o && dec_pass_o)); // R6
endmodule

// File: tb/acs4_radix4_unit_tb_top.sv
module acs4_radix4_unit_tb_top;
  localparam int SM_W = 11;
  localparam int BM_W = 9;
  localparam int NST  = 4;
  localparam int NDP  = 2;

  logic clk;
  logic rst_n;
  logic sym_start;
  logic [NST*SM_W-1:0]      pred;
  logic [NST*NST*BM_W-1:0]  bm;
  logic [NST*SM_W-1:0]      sm_o;
  logic                     dec_vld, dec_pass;
  logic [2*NDP-1:0]         dec;

  acs4_radix4_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_start_i(sym_start),
    .pred_sm_i  (pred),
    .bm_i       (bm),
    .sm_o       (sm_o),
    .dec_vld_o  (dec_vld),
    .dec_pass_o (dec_pass),
    .dec_o      (dec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string req_tag = "R1";

  logic             exp_dv  [16];
  logic             exp_dp  [16];
  logic [2*NDP-1:0] exp_dec [16];
  logic [NST*SM_W-1:0] sm_exp, sm_pend;
  int sm_sw = -1;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) cyc=%0d actual=%0h expected=%0h", what, req_tag, cyc, act, exp);
    end
  endtask

  task automatic compare_now();
    int slot = cyc % 16;
    chk("R10 decision valid", 64'(dec_vld), 64'(exp_dv[slot]));
    if (exp_dv[slot]) begin
      chk("R5 pass tag", 64'(dec_pass), 64'(exp_dp[slot]));
      chk("R4 decisions", 64'(dec), 64'(exp_dec[slot]));
    end
    exp_dv[slot] = 1'b0;
    if (cyc == sm_sw) sm_exp = sm_pend;
    chk("R2/R6 state metrics", 64'(sm_o), 64'(sm_exp));
  endtask

  // Behavioural reference: linear scan keeping the best so far.
  task automatic schedule();
    logic [SM_W-1:0] c [NST];
    logic [1:0]      win [NST];
    logic [SM_W-1:0] diff;
    for (int s = 0; s < NST; s++) begin
      int best = 0;
      for (int b = 0; b < NST; b++)
        c[b] = pred[b*SM_W +: SM_W] + SM_W'(bm[(s*NST+b)*BM_W +: BM_W]);
      for (int b = 1; b < NST; b++) begin
        diff = c[b] - c[best];
        if (diff[SM_W-1]) best = b;
      end
      win[s] = 2'(best);
      sm_pend[s*SM_W +: SM_W] = c[best];
    end
    exp_dv[(cyc+6)%16]  = 1'b1;
    exp_dp[(cyc+6)%16]  = 1'b0;
    exp_dec[(cyc+6)%16] = {win[1], win[0]};
    exp_dv[(cyc+7)%16]  = 1'b1;
    exp_dp[(cyc+7)%16]  = 1'b1;
    exp_dec[(cyc+7)%16] = {win[3], win[2]};
    sm_sw = cyc + 7;
  endtask

  task automatic step(input logic st);
    sym_start = st;
    if (st) schedule();
    @(negedge clk);
    compare_now();
  endtask

  task automatic noise();
    for (int i = 0; i < NST; i++) pred[i*SM_W +: SM_W] = SM_W'($urandom);
    for (int i = 0; i < NST*NST; i++) bm[i*BM_W +: BM_W] = BM_W'($urandom);
  endtask

  task automatic load(input int base, input int spread, input int bm_max);
    for (int i = 0; i < NST; i++)
      pred[i*SM_W +: SM_W] = SM_W'(base + int'($urandom % spread));
    for (int i = 0; i < NST*NST; i++)
      bm[i*BM_W +: BM_W] = BM_W'($urandom % bm_max);
  endtask

  // One iteration: start, then gap-1 idle cycles with inputs scrambled (R7).
  task automatic iterate(input int gap);
    step(1'b1);
    for (int g = 1; g < gap; g++) begin
      noise();
      step(1'b0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      exp_dv[i] = 1'b0; exp_dp[i] = 1'b0; exp_dec[i] = '0;
    end
    sm_exp = '0; sm_pend = '0;
    rst_n = 1'b0; sym_start = 1'b0; pred = '0; bm = '0;
    repeat (3) @(negedge clk);
    req_tag = "R1";
    chk("R1 reset metrics", 64'(sm_o), 64'd0);
    chk("R1 reset valid", 64'(dec_vld), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0);

    req_tag = "R2";
    for (int k = 0; k < 20; k++) begin
      load(int'($urandom % 2048), 400, 512);
      iterate(7 + int'($urandom % 3));
    end

    req_tag = "R3";
    for (int k = 0; k < 4; k++) begin
      int v = int'($urandom % 2048);
      int w = int'($urandom % 512);
      for (int i = 0; i < NST; i++) pred[i*SM_W +: SM_W] = SM_W'(v);
      for (int i = 0; i < NST*NST; i++) bm[i*BM_W +: BM_W] = BM_W'(w);
      iterate(7);
    end
    for (int k = 0; k < 24; k++) begin
      load(int'($urandom % 2048), 3, 3);
      iterate(7);
    end

    req_tag = "R9";
    for (int k = 0; k < 20; k++) begin
      load(1700 + int'($urandom % 348), 400, 512);
      iterate(7 + int'($urandom % 2));
    end

    req_tag = "R8";
    for (int k = 0; k < 40; k++) begin
      pred = sm_o;
      for (int i = 0; i < NST*NST; i++) bm[i*BM_W +: BM_W] = BM_W'($urandom % 512);
      iterate(7);
    end

    req_tag = "R7";
    for (int k = 0; k < 10; k++) begin
      load(int'($urandom % 2048), 400, 512);
      iterate(11);
    end
    for (int i = 0; i < 4; i++) step(1'b0);

    req_tag = "R1";
    rst_n = 1'b0;
    #1;
    chk("R1 async reset metrics", 64'(sm_o), 64'd0);
    chk("R1 async reset valid", 64'(dec_vld), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", req_tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule